// File: doc/BRIEF.md
# Serial Control Register Slave

This block receives configuration over a three-wire synchronous serial control bus: a serial clock, a data line that the slave can pull low, and a vertical reset strobe. It converts each transaction into a register write or an identification read. A transaction is sixteen serial clock rising edges: an address byte followed by a data byte, each sent least significant bit first with no parity. The serial clock, the data line and the strobe are each synchronised into the system clock domain. Every bit is sampled on the detected rising edge of the serial clock.

Nine writable registers sit at addresses 0x40 to 0x48 and are held in a shadow bank. The whole shadow bank is copied into the active bank, which drives the configuration outputs for the scaler datapath. The copy happens as soon as a write completes if the deferred-transfer bit is clear. If that bit is set, the copy waits for the next rising edge of the vertical reset strobe. At that strobe edge the block can also emit a one-cycle initialisation pulse for the datapath. Address 0x49 is an identification read, and the slave answers it by pulling the data line low for the whole data byte.

Top module: `ctl_serial_regs`

## Requirements
- R1: After reset every configuration output, `ser_pull_low_o` and `init_pulse_o` are 0.
- R2: A frame is 16 serial clock rising edges. The first 8 carry the address and the last 8 carry the data, and each byte starts with bit 0.
- R3: While the deferred-transfer bit (bit 4 of register 0x48) is clear, a completed write to 0x40..0x48 copies the whole shadow bank to the active outputs within 5 system clocks of the 16th rising edge. The register-to-output mapping is 0x40 `outer_left_o`, 0x41 `inner_left_o`, 0x42 `inner_right_o`, 0x43 `outer_right_o`, 0x44 `line_len_o`, 0x45 `base_incr_o`.
- R4: Register 0x46 maps bits 5:0 to `curve_a_o` and bit 6 to `split_en_o`. Register 0x47 maps bits 5:0 to `curve_b_o`, bit 6 to `test_a_o` and bit 7 to `notch_en_o`. Register 0x48 maps bit 0 to `zoom_o`, bit 1 to `in_shift_o`, bit 2 to `out_shift_o`, bit 3 to init, bit 4 to deferred transfer, bit 5 to `keep_o`, bit 6 to `test_b_o` and bit 7 to `adapt_o`.
- R5: While the shadow deferred-transfer bit is set, writes update only the shadow bank. The active outputs stay unchanged until a rising edge of `vrst_i`, which copies the whole shadow bank.
- R6: On a rising edge of `vrst_i`, `init_pulse_o` is high for exactly one cycle if shadow bit 3 of 0x48 is set. Otherwise it stays low.
- R7: When the address byte is 0x49, `ser_pull_low_o` goes high after the address byte and stays high through the data byte. It is low again once the frame ends, and no register changes.
- R8: Frames to any address outside 0x40..0x49 change no output and never assert `ser_pull_low_o`.
- R9: If no serial rising edge arrives for `IDLE_CYCLES` system clocks, a partial frame is discarded and the next rising edge starts a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial bus clock |
| ser_dat_i | input | 1 | Serial bus data as seen on the line |
| vrst_i | input | 1 | Vertical reset strobe |
| ser_pull_low_o | output | 1 | Pull the data line low (identification reply) |
| outer_left_o | output | 8 | Outer left curve position |
| inner_left_o | output | 8 | Inner left curve position |
| inner_right_o | output | 8 | Inner right curve position |
| outer_right_o | output | 8 | Outer right curve position |
| line_len_o | output | 8 | Output samples per line code |
| base_incr_o | output | 8 | Constant rate increment for the centre area |
| curve_a_o | output | 6 | Second derivative for the inner side areas |
| split_en_o | output | 1 | Odd/even stream split enable |
| curve_b_o | output | 6 | Second derivative for the outer side areas |
| test_a_o | output | 1 | Test control A |
| notch_en_o | output | 1 | Luminance notch enable |
| zoom_o | output | 1 | Zoom (1) or compress (0) in the centre area |
| in_shift_o | output | 1 | Shifted write-enable timing on input |
| out_shift_o | output | 1 | Shifted write-enable timing on output |
| keep_o | output | 1 | Keep the curve from the last line |
| test_b_o | output | 1 | Test control B |
| adapt_o | output | 1 | Adapt control |
| init_pulse_o | output | 1 | One-cycle datapath initialisation pulse |

## Verification
On every cycle, the assertions check that the initialisation pulse lasts one cycle and only follows a strobe edge. They also check that the data-line pull starts only with a decoded address byte and is released when the frame ends. Finally, they check that the active bank moves only on a write completion or a strobe edge, and the shadow bank only on a write completion. The register-to-output mapping, the least-significant-bit-first order, the deferred transfer and the idle resynchronisation can only be shown by the bench's frame scenarios. The same holds for ignoring foreign addresses, because each of these depends on the bit values a whole frame carries.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int REG_COUNT = 9;
  localparam int IDX_OUTER_L = 0;
  localparam int IDX_INNER_L = 1;
  localparam int IDX_INNER_R = 2;
  localparam int IDX_OUTER_R = 3;
  localparam int IDX_LINE = 4;
  localparam int IDX_BASE = 5;
  localparam int IDX_CURVE_A = 6;
  localparam int IDX_CURVE_B = 7;
  localparam int IDX_MODE = REG_COUNT - 1;

  typedef logic [REG_COUNT-1:0][7:0] bank_t;

  typedef struct packed {
    logic adapt;
    logic test_b;
    logic keep;
    logic defer;
    logic init;
    logic out_shift;
    logic in_shift;
    logic zoom;
  } mode_t;
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/ctl_frame_rx.sv
module ctl_frame_rx #(
  parameter int         IDLE_CYCLES = 1024,
  parameter logic [7:0] ID_ADDR = 8'h49
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       sdat_i,
  output logic [7:0] addr_o,
  output logic [7:0] data_o,
  output logic       addr_stb_o,
  output logic       frame_done_o,
  output logic       pull_low_o
);
  localparam int CNT_W = $clog2(IDLE_CYCLES + 1);

  logic             sclk_q;
  logic [7:0]       shift_q;
  logic [3:0]       bit_q;
  logic [CNT_W-1:0] idle_q;
  logic             rise;
  logic             timeout;
  logic [7:0]       byte_nxt;

  assign rise     = sclk_i & ~sclk_q;
  assign timeout  = idle_q == CNT_W'(IDLE_CYCLES);
  assign byte_nxt = {sdat_i, shift_q[7:1]};  // bit 0 arrives first

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q       <= 1'b0;
      shift_q      <= '0;
      bit_q        <= '0;
      idle_q       <= '0;
      addr_o       <= '0;
      data_o       <= '0;
      addr_stb_o   <= 1'b0;
      frame_done_o <= 1'b0;
      pull_low_o   <= 1'b0;
    end else begin
      sclk_q       <= sclk_i;
      addr_stb_o   <= 1'b0;
      frame_done_o <= 1'b0;
      if (rise) begin
        shift_q <= byte_nxt;
        bit_q   <= bit_q + 4'd1;
        idle_q  <= '0;
        if (bit_q == 4'd7) begin
          addr_o     <= byte_nxt;
          addr_stb_o <= 1'b1;
          pull_low_o <= (byte_nxt == ID_ADDR);
        end
        if (bit_q == 4'd15) begin
          data_o       <= byte_nxt;
          frame_done_o <= 1'b1;
          pull_low_o   <= 1'b0;
        end
      end else if (timeout) begin
        bit_q      <= '0;
        pull_low_o <= 1'b0;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_done_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] data_i,
  input  logic       vrst_rise_i,
  output bank_t      shadow_o,
  output bank_t      active_o,
  output logic       init_pulse_o
);
  logic [7:0] offs;
  logic       wr_hit;
  bank_t      shadow_nxt;
  mode_t      mode_nxt;
  mode_t      mode_cur;

  assign offs     = addr_i - BASE_ADDR;
  assign wr_hit   = frame_done_i && (offs < 8'(REG_COUNT));
  assign mode_nxt = mode_t'(shadow_nxt[IDX_MODE]);
  assign mode_cur = mode_t'(shadow_o[IDX_MODE]);

  always_comb begin
    shadow_nxt = shadow_o;
    for (int i = 0; i < REG_COUNT; i++)
      if (wr_hit && offs == 8'(i)) shadow_nxt[i] = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_o     <= '0;
      active_o     <= '0;
      init_pulse_o <= 1'b0;
    end else begin
      init_pulse_o <= vrst_rise_i && mode_cur.init;
      if (vrst_rise_i) active_o <= shadow_o;
      if (wr_hit) begin
        shadow_o <= shadow_nxt;
        if (!mode_nxt.defer) active_o <= shadow_nxt;
      end
    end
  end
endmodule

// File: rtl/ctl_serial_regs.sv
module ctl_serial_regs
  import ctl_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h40,
  parameter int         IDLE_CYCLES = 1024,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ser_clk_i,
  input  logic       ser_dat_i,
  input  logic       vrst_i,
  output logic       ser_pull_low_o,
  output logic [7:0] outer_left_o,
  output logic [7:0] inner_left_o,
  output logic [7:0] inner_right_o,
  output logic [7:0] outer_right_o,
  output logic [7:0] line_len_o,
  output logic [7:0] base_incr_o,
  output logic [5:0] curve_a_o,
  output logic       split_en_o,
  output logic [5:0] curve_b_o,
  output logic       test_a_o,
  output logic       notch_en_o,
  output logic       zoom_o,
  output logic       in_shift_o,
  output logic       out_shift_o,
  output logic       keep_o,
  output logic       test_b_o,
  output logic       adapt_o,
  output logic       init_pulse_o
);
  localparam logic [7:0] ID_ADDR = BASE_ADDR + 8'(REG_COUNT);

  logic [2:0] raw_in, sync_in;
  logic       sclk_s, sdat_s, vrst_s, vrst_q, vrst_rise;
  logic [7:0] addr, data;
  logic       addr_stb, frame_done;
  bank_t      shadow_q, active_q;
  mode_t      mode;

  assign raw_in = {vrst_i, ser_dat_i, ser_clk_i};
  assign {vrst_s, sdat_s, sclk_s} = sync_in;

  ctl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw_in), .q_o(sync_in)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vrst_q <= 1'b0;
    else         vrst_q <= vrst_s;
  end
  assign vrst_rise = vrst_s & ~vrst_q;

  ctl_frame_rx #(.IDLE_CYCLES(IDLE_CYCLES), .ID_ADDR(ID_ADDR)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_s), .sdat_i(sdat_s),
    .addr_o(addr), .data_o(data), .addr_stb_o(addr_stb),
    .frame_done_o(frame_done), .pull_low_o(ser_pull_low_o)
  );

  ctl_reg_bank #(.BASE_ADDR(BASE_ADDR)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_done_i(frame_done),
    .addr_i(addr), .data_i(data), .vrst_rise_i(vrst_rise),
    .shadow_o(shadow_q), .active_o(active_q), .init_pulse_o(init_pulse_o)
  );

  assign mode          = mode_t'(active_q[IDX_MODE]);
  assign outer_left_o  = active_q[IDX_OUTER_L];
  assign inner_left_o  = active_q[IDX_INNER_L];
  assign inner_right_o = active_q[IDX_INNER_R];
  assign outer_right_o = active_q[IDX_OUTER_R];
  assign line_len_o    = active_q[IDX_LINE];
  assign base_incr_o   = active_q[IDX_BASE];
  assign curve_a_o     = active_q[IDX_CURVE_A][5:0];
  assign split_en_o    = active_q[IDX_CURVE_A][6];
  assign curve_b_o     = active_q[IDX_CURVE_B][5:0];
  assign test_a_o      = active_q[IDX_CURVE_B][6];
  assign notch_en_o    = active_q[IDX_CURVE_B][7];
  assign zoom_o        = mode.zoom;
  assign in_shift_o    = mode.in_shift;
  assign out_shift_o   = mode.out_shift;
  assign keep_o        = mode.keep;
  assign test_b_o      = mode.test_b;
  assign adapt_o       = mode.adapt;

  logic unused_bits;
  assign unused_bits = ^{active_q[IDX_CURVE_A][7], mode.init, mode.defer};
endmodule

// File: rtl/ctl_serial_regs_chk.sv
module ctl_serial_regs_chk
  import ctl_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  frame_done_i,
  input logic  addr_stb_i,
  input logic  vrst_rise_i,
  input logic  pull_low_i,
  input logic  init_pulse_i,
  input bank_t shadow_i,
  input bank_t active_i
);
  AST_INIT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_pulse_i |=> !init_pulse_i); // R6
  AST_INIT_FROM_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_pulse_i |-> $past(vrst_rise_i)); // R6
  AST_PULL_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_low_i) |-> addr_stb_i); // R7
  AST_PULL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i |-> !pull_low_i); // R7
  AST_ACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_done_i && !vrst_rise_i) |=> $stable(active_i)); // R5
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_done_i |=> $stable(shadow_i)); // R3
endmodule

bind ctl_serial_regs ctl_serial_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_done_i(frame_done),
  .addr_stb_i(addr_stb), .vrst_rise_i(vrst_rise), .pull_low_i(ser_pull_low_o),
  .init_pulse_i(init_pulse_o), .shadow_i(shadow_q), .active_i(active_q)
);

// File: tb/ctl_serial_regs_test.sv
module ctl_serial_regs_test;
  localparam int HALF = 8;
  localparam int IDLE = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, vrst = 1'b0;
  logic pull, init_p, split, test_a, notch, zoom, in_sh, out_sh, keep, test_b, adapt;
  logic [7:0] ol, il, ir, orr, len, base;
  logic [5:0] ca, cb;

  int total = 0, bad = 0;
  bit settled = 1'b0, done = 1'b0;
  string cur_req = "R1";
  logic [7:0] sh [9];
  logic [7:0] ac [9];

  always #4 clk = ~clk;

  ctl_serial_regs #(.IDLE_CYCLES(IDLE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .vrst_i(vrst), .ser_pull_low_o(pull), .outer_left_o(ol), .inner_left_o(il),
    .inner_right_o(ir), .outer_right_o(orr), .line_len_o(len), .base_incr_o(base),
    .curve_a_o(ca), .split_en_o(split), .curve_b_o(cb), .test_a_o(test_a),
    .notch_en_o(notch), .zoom_o(zoom), .in_shift_o(in_sh), .out_shift_o(out_sh),
    .keep_o(keep), .test_b_o(test_b), .adapt_o(adapt), .init_pulse_o(init_p)
  );

  function automatic logic [70:0] act_vec();
    return {ol, il, ir, orr, len, base, split, ca, notch, test_a, cb,
            adapt, test_b, keep, out_sh, in_sh, zoom, pull, init_p};
  endfunction

  function automatic logic [70:0] exp_vec();
    return {ac[0], ac[1], ac[2], ac[3], ac[4], ac[5], ac[6][6], ac[6][5:0],
            ac[7][7], ac[7][6], ac[7][5:0], ac[8][7], ac[8][6], ac[8][5],
            ac[8][2], ac[8][1], ac[8][0], 1'b0, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [70:0] a, input logic [70:0] e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, a, e);
    end
  endtask

  always @(negedge clk)
    if (settled && !done) chk(act_vec() === exp_vec(), cur_req, "outputs", act_vec(), exp_vec());

  function automatic void model_write(input logic [7:0] a, input logic [7:0] d);
    if (a >= 8'h40 && a <= 8'h48) begin
      sh[a - 8'h40] = d;
      if (!sh[8][4]) ac = sh;
    end
  endfunction

  task automatic send_frame(input logic [7:0] a, input logic [7:0] d);
    logic seen = 1'b0, mid = 1'b0;
    settled = 1'b0;
    for (int i = 0; i < 16; i++) begin
      ser_dat = (i < 8) ? a[i] : d[i-8];
      repeat (HALF) begin @(negedge clk); seen |= pull; end
      if (i == 12) mid = pull;
      ser_clk = 1'b1;
      repeat (HALF) begin @(negedge clk); seen |= pull; end
      ser_clk = 1'b0;
    end
    repeat (4) @(negedge clk);
    model_write(a, d);
    if (a == 8'h49) begin
      chk(mid === 1'b1, "R7", "pull mid data byte", 71'(mid), 71'(1));
      chk(seen === 1'b1, "R7", "pull seen", 71'(seen), 71'(1));
    end else begin
      chk(seen === 1'b0, (a >= 8'h40 && a <= 8'h48) ? "R3" : "R8", "no pull", 71'(seen), 71'(0));
    end
    settled = 1'b1;
  endtask

  task automatic strobe();
    int cnt = 0;
    int exp_cnt;
    settled = 1'b0;
    exp_cnt = int'(sh[8][3]);
    @(negedge clk); vrst = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i == 3) vrst = 1'b0;
      cnt += int'(init_p);
    end
    ac = sh;
    chk(cnt == exp_cnt, "R6", "init pulse count", 71'(cnt), 71'(exp_cnt));
    settled = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 9; i++) begin sh[i] = 8'h00; ac[i] = 8'h00; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(act_vec() === 71'(0), "R1", "reset state", act_vec(), 71'(0));
    settled = 1'b1;
    repeat (20) @(negedge clk);

    cur_req = "R2 R3";
    send_frame(8'h40, 8'hA5);
    send_frame(8'h41, 8'h01);
    send_frame(8'h42, 8'h80);
    send_frame(8'h43, 8'h3C);
    send_frame(8'h44, 8'hB4);
    send_frame(8'h45, 8'h7E);
    repeat (10) @(negedge clk);

    cur_req = "R4";
    send_frame(8'h46, 8'hFF);
    send_frame(8'h47, 8'hC5);
    send_frame(8'h48, 8'hE7);
    send_frame(8'h46, 8'h2A);
    repeat (10) @(negedge clk);

    cur_req = "R8";
    send_frame(8'h3F, 8'h55);
    send_frame(8'h4A, 8'h12);
    send_frame(8'hFF, 8'h33);
    send_frame(8'h00, 8'hFF);

    cur_req = "R7";
    send_frame(8'h49, 8'hFF);
    repeat (10) @(negedge clk);

    cur_req = "R5";
    send_frame(8'h48, 8'h10);
    send_frame(8'h40, 8'h11);
    send_frame(8'h45, 8'h99);
    repeat (30) @(negedge clk);
    strobe();
    repeat (10) @(negedge clk);

    cur_req = "R6";
    send_frame(8'h48, 8'h18);
    strobe();
    send_frame(8'h48, 8'h00);
    strobe();

    cur_req = "R9";
    settled = 1'b0;
    for (int i = 0; i < 3; i++) begin
      ser_dat = 1'b1;
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b1;
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (IDLE + 20) @(negedge clk);
    settled = 1'b1;
    send_frame(8'h42, 8'h5A);
    send_frame(8'h43, 8'hC3);
    repeat (10) @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule